// File: doc/BRIEF.md
# Fixed-Resolution Platform Timebase Counter

This block is a free-running 64-bit machine timer whose visible count always advances in architectural ticks of 10 ns (100,000 ticks per millisecond), regardless of the frequency of the clock that updates it. On every update cycle it adds a programmable unsigned fixed-point increment (32 integer bits, 32 fraction bits) to an internal 96-bit accumulator. The upper 64 bits form the readable timer value. The lower 32 bits hold a fraction that software never sees. An update clock slower than 100 MHz uses an integer step larger than one (for example 5.0 at 20 MHz). A faster update clock uses a fractional step (for example about 0.04 at 2.5 GHz). The lowest supported update frequency is 10 MHz, which corresponds to a step of 10.0.

A 64-bit compare register drives a level timer interrupt. The interrupt is high whenever the timer value is greater than or equal to the compare value. Software arms a deadline by writing the compare register with the current timer value plus the delay in ticks. A simple word-addressed register port gives access to the timer value, the compare value and the increment, each as two 32-bit halves. Reading the low half of the timer or of the compare register captures the matching high half, so that two reads give one consistent 64-bit value.

Top module: `timebase_counter`

## Requirements
- R1: After reset the timer value and hidden fraction are 0, the increment is 1.0 (integer 1, fraction 0), the compare value is all ones, the interrupt is low and the read data is 0.
- R2: On every clock edge without a timer write, the accumulator {timer value, fraction} gains the 32.32 increment. With an integer increment the timer value advances by exactly that integer per cycle. For example, a step of 2.0 on a 50 MHz clock gives 10,000 ticks in 100 us.
- R3: With a fractional increment, after k update cycles from a fraction of zero, the timer value equals the start value plus floor(k x increment). The fraction bits never appear in the timer value.
- R4: In every cycle without a timer write, the timer value advances by either the integer part of the increment or the integer part plus one, modulo 2^64. The accumulator wraps modulo 2^96 silently, so all ones plus 1.5 gives a timer value of 0.
- R5: An increment of zero freezes the timer value.
- R6: A write to either timer half loads that half from the write data, keeps the other half, clears the hidden fraction, and takes priority over the increment in that cycle.
- R7: The interrupt output equals (timer value >= compare value) and is recomputed every cycle. A compare write is reflected in the interrupt in the cycle after the write edge.
- R8: The register index `reg_addr` selects 0 = timer low, 1 = timer high, 2 = compare low, 3 = compare high, 4 = increment fraction, 5 = increment integer. Each low half is at index n and its high half at n+1 (byte offsets 0 and 4). Read data is registered and appears in the cycle after `reg_rd`. Indices 6 and 7 read as 0 and ignore writes. Read data holds when no read is issued.
- R9: A read of the timer low half (or the compare low half) captures that register's high half. A later read of index 1 (or 3) returns the captured value, not the live one. Both captures are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock; one accumulation per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| timer_value | output | 64 | Visible integer timer value |
| timer_irq | output | 1 | Level timer interrupt |

## Verification
The timer value changes on the same edge that samples a write or an increment, so the bench drives every strobe at a falling edge and checks the value at the next falling edge. In each sweep, the k-th falling edge after the timer load is compared against the start value plus floor(k x increment), computed in 128-bit arithmetic. The interrupt follows the timer and compare registers with no added delay, so it is checked in the cycle after the write that changes either register. Read data takes one register stage and is checked one cycle after the read strobe. The high-half capture is tested by letting the low half wrap between the two reads.

// File: rtl/tbc_pkg.sv
`timescale 1ns/1ps
package tbc_pkg;
   typedef enum logic [2:0] {
      TBC_TMR_LO = 3'd0,
      TBC_TMR_HI = 3'd1,
      TBC_CMP_LO = 3'd2,
      TBC_CMP_HI = 3'd3,
      TBC_INC_FR = 3'd4,
      TBC_INC_IN = 3'd5
   } tbc_idx_e;

   typedef struct packed {
      logic tmr_lo;
      logic tmr_hi;
      logic cmp_lo;
      logic cmp_hi;
      logic inc_fr;
      logic inc_in;
   } tbc_wr_s;
endpackage

// File: rtl/tbc_regport.sv
`timescale 1ns/1ps
module tbc_regport
   import tbc_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [2:0]         addr,
   input  logic [2*REG_W-1:0] tmr_value,
   input  logic [2*REG_W-1:0] cmp_value,
   input  logic [REG_W-1:0]   inc_int,
   input  logic [REG_W-1:0]   inc_frac,
   output tbc_wr_s            wr_strb,
   output logic [REG_W-1:0]   rdata
);
   localparam int VIS_W = 2 * REG_W;

   logic [REG_W-1:0] tmr_hi_hold;
   logic [REG_W-1:0] cmp_hi_hold;

   always_comb begin
      wr_strb = '0;
      if (wr_en) begin
         case (tbc_idx_e'(addr))
            TBC_TMR_LO: wr_strb.tmr_lo = 1'b1;
            TBC_TMR_HI: wr_strb.tmr_hi = 1'b1;
            TBC_CMP_LO: wr_strb.cmp_lo = 1'b1;
            TBC_CMP_HI: wr_strb.cmp_hi = 1'b1;
            TBC_INC_FR: wr_strb.inc_fr = 1'b1;
            TBC_INC_IN: wr_strb.inc_in = 1'b1;
            default:    wr_strb = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata       <= '0;
         tmr_hi_hold <= '0;
         cmp_hi_hold <= '0;
      end else if (rd_en) begin
         case (tbc_idx_e'(addr))
            TBC_TMR_LO: begin
               rdata       <= tmr_value[REG_W-1:0];
               tmr_hi_hold <= tmr_value[VIS_W-1:REG_W];
            end
            TBC_TMR_HI: rdata <= tmr_hi_hold;
            TBC_CMP_LO: begin
               rdata       <= cmp_value[REG_W-1:0];
               cmp_hi_hold <= cmp_value[VIS_W-1:REG_W];
            end
            TBC_CMP_HI: rdata <= cmp_hi_hold;
            TBC_INC_FR: rdata <= inc_frac;
            TBC_INC_IN: rdata <= inc_int;
            default:    rdata <= '0;
         endcase
      end
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)) else $error("AST_RD_HOLD"); // R8
endmodule

// File: rtl/tbc_accum.sv
`timescale 1ns/1ps
module tbc_accum #(
   parameter int REG_W         = 32,
   parameter int FRAC_W        = 32,
   parameter int RESET_INC_INT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tmr_wr_lo,
   input  logic                 tmr_wr_hi,
   input  logic                 inc_wr_fr,
   input  logic                 inc_wr_in,
   input  logic [REG_W-1:0]     wdata,
   output logic [2*REG_W-1:0]   val_q,
   output logic [REG_W-1:0]     inc_int_q,
   output logic [REG_W-1:0]     inc_frac_view
);
   localparam int VIS_W = 2 * REG_W;
   localparam int ACC_W = VIS_W + FRAC_W;
   localparam int PAD_W = REG_W - FRAC_W;

   logic             tmr_wr;
   logic [REG_W-1:0] frac_view;

   assign tmr_wr = tmr_wr_lo | tmr_wr_hi;

   always_ff @(posedge clk) begin
      if (!rst_n)         inc_int_q <= REG_W'(RESET_INC_INT);
      else if (inc_wr_in) inc_int_q <= wdata;
   end

   generate
      if (FRAC_W > 0) begin : g_frac
         logic [FRAC_W-1:0] frac_q;
         logic [FRAC_W-1:0] inc_frac_q;
         logic [ACC_W-1:0]  acc_sum;

         assign acc_sum = {val_q, frac_q} + ACC_W'({inc_int_q, inc_frac_q});

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               val_q  <= '0;
               frac_q <= '0;
            end else if (tmr_wr) begin
               if (tmr_wr_lo) val_q[REG_W-1:0]     <= wdata;
               if (tmr_wr_hi) val_q[VIS_W-1:REG_W] <= wdata;
               frac_q <= '0;
            end else begin
               {val_q, frac_q} <= acc_sum;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)         inc_frac_q <= '0;
            else if (inc_wr_fr) inc_frac_q <= FRAC_W'(wdata >> PAD_W);
         end

         assign frac_view     = REG_W'(frac_q) << PAD_W;
         assign inc_frac_view = REG_W'(inc_frac_q) << PAD_W;
      end else begin : g_int
         logic [VIS_W-1:0] int_sum;
         assign int_sum = val_q + VIS_W'(inc_int_q);

         always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else if (tmr_wr) begin
               if (tmr_wr_lo) val_q[REG_W-1:0]     <= wdata;
               if (tmr_wr_hi) val_q[VIS_W-1:REG_W] <= wdata;
            end else begin
               val_q <= int_sum;
            end
         end

         assign frac_view     = '0;
         assign inc_frac_view = '0;
      end
   endgenerate

   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_wr |=> ((val_q - $past(val_q)) == VIS_W'($past(inc_int_q))) ||
                  ((val_q - $past(val_q)) == VIS_W'($past(inc_int_q)) + VIS_W'(1)))
      else $error("AST_STEP"); // R4
   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_wr && inc_int_q == '0 && inc_frac_view == '0) |=> $stable(val_q) && $stable(frac_view))
      else $error("AST_FREEZE"); // R5
   AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wr_lo |=> (val_q[REG_W-1:0] == $past(wdata)) && (frac_view == '0))
      else $error("AST_LOAD_LO"); // R6
   AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wr_hi |=> (val_q[VIS_W-1:REG_W] == $past(wdata)) && (frac_view == '0))
      else $error("AST_LOAD_HI"); // R6
endmodule

// File: rtl/tbc_compare.sv
`timescale 1ns/1ps
module tbc_compare #(
   parameter int REG_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [REG_W-1:0]   wdata,
   input  logic               tmr_wr,
   input  logic [2*REG_W-1:0] tmr_value,
   output logic [2*REG_W-1:0] cmp_q,
   output logic               irq
);
   localparam int VIS_W = 2 * REG_W;

   always_ff @(posedge clk) begin
      if (!rst_n) cmp_q <= '1;
      else begin
         if (wr_lo) cmp_q[REG_W-1:0]     <= wdata;
         if (wr_hi) cmp_q[VIS_W-1:REG_W] <= wdata;
      end
   end

   assign irq = (tmr_value >= cmp_q);

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_lo && !wr_hi && !tmr_wr) |=> irq || (tmr_value < $past(tmr_value)))
      else $error("AST_IRQ_HOLD"); // R7
endmodule

// File: rtl/timebase_counter.sv
`timescale 1ns/1ps
module timebase_counter
   import tbc_pkg::*;
#(
   parameter int REG_W         = 32,
   parameter int FRAC_W        = 32,
   parameter int RESET_INC_INT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [2:0]           reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic [2*REG_W-1:0]   timer_value,
   output logic                 timer_irq
);
   localparam int VIS_W = 2 * REG_W;

   initial begin
      if (REG_W < 8)       $fatal(1, "REG_W must be at least 8");
      if (FRAC_W < 0)      $fatal(1, "FRAC_W must not be negative");
      if (FRAC_W > REG_W)  $fatal(1, "FRAC_W must fit one register half");
      if (RESET_INC_INT < 0) $fatal(1, "RESET_INC_INT must not be negative");
   end

   tbc_wr_s          wr_strb;
   logic [VIS_W-1:0] cmp_value;
   logic [REG_W-1:0] inc_int;
   logic [REG_W-1:0] inc_frac;

   tbc_regport #(.REG_W(REG_W)) u_regport (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .rd_en     (reg_rd),
      .addr      (reg_addr),
      .tmr_value (timer_value),
      .cmp_value (cmp_value),
      .inc_int   (inc_int),
      .inc_frac  (inc_frac),
      .wr_strb   (wr_strb),
      .rdata     (reg_rdata)
   );

   tbc_accum #(.REG_W(REG_W), .FRAC_W(FRAC_W), .RESET_INC_INT(RESET_INC_INT)) u_accum (
      .clk           (clk),
      .rst_n         (rst_n),
      .tmr_wr_lo     (wr_strb.tmr_lo),
      .tmr_wr_hi     (wr_strb.tmr_hi),
      .inc_wr_fr     (wr_strb.inc_fr),
      .inc_wr_in     (wr_strb.inc_in),
      .wdata         (reg_wdata),
      .val_q         (timer_value),
      .inc_int_q     (inc_int),
      .inc_frac_view (inc_frac)
   );

   tbc_compare #(.REG_W(REG_W)) u_compare (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (wr_strb.cmp_lo),
      .wr_hi     (wr_strb.cmp_hi),
      .wdata     (reg_wdata),
      .tmr_wr    (wr_strb.tmr_lo | wr_strb.tmr_hi),
      .tmr_value (timer_value),
      .cmp_q     (cmp_value),
      .irq       (timer_irq)
   );
endmodule

// File: tb/timebase_counter_bench.sv
`timescale 1ns/1ps
module timebase_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] timer_value;
   logic        timer_irq;

   int unsigned checks = 0;
   int unsigned failures = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   timebase_counter u_timebase_counter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .timer_value(timer_value), .timer_irq(timer_irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = idx;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic set_inc(input logic [31:0] ip, input logic [31:0] fp);
      reg_write(3'd4, fp);
      reg_write(3'd5, ip);
   endtask

   task automatic set_timer(input logic [63:0] v);
      reg_write(3'd1, v[63:32]);
      reg_write(3'd0, v[31:0]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0]  rd;
      logic [31:0]  ints [4];
      logic [31:0]  fracs [4];
      logic [63:0]  base;
      logic [63:0]  prev;
      logic [127:0] prod;
      ints  = '{32'd0, 32'd1, 32'd2, 32'd5};
      fracs = '{32'h0, 32'h0A3D70A4, 32'h8000_0000, 32'hFFFF_FFFF};

      repeat (3) @(negedge clk);
      chk("R1 timer", timer_value, 64'd0);
      chk("R1 irq", {63'd0, timer_irq}, 64'd0);
      chk("R1 rdata", {32'd0, reg_rdata}, 64'd0);
      rst_n = 1'b1;

      reg_read(3'd5, rd); chk("R1 R8 inc int", {32'd0, rd}, 64'd1);
      reg_read(3'd4, rd); chk("R1 R8 inc frac", {32'd0, rd}, 64'd0);
      reg_read(3'd2, rd); chk("R1 R8 cmp lo", {32'd0, rd}, 64'hFFFF_FFFF);
      reg_read(3'd3, rd); chk("R1 R9 cmp hi", {32'd0, rd}, 64'hFFFF_FFFF);
      reg_read(3'd6, rd); chk("R8 unmapped", {32'd0, rd}, 64'd0);
      repeat (3) @(negedge clk);
      chk("R8 rdata hold", {32'd0, reg_rdata}, 64'd0);

      // sweep of integer and fractional increments
      base = 64'h0000_0001_FFFF_FFC0;
      foreach (ints[i]) begin
         foreach (fracs[j]) begin
            set_inc(ints[i], fracs[j]);
            set_timer(base);
            reg_read(3'd5, rd); chk("R8 inc int readback", {32'd0, rd}, {32'd0, ints[i]});
            set_timer(base);
            prev = base;
            for (int k = 1; k <= 40; k++) begin
               @(negedge clk);
               prod = 128'(k) * {64'd0, ints[i], fracs[j]};
               if (ints[i] == 0 && fracs[j] == 0)
                  chk("R5 frozen", timer_value, base);
               else if (fracs[j] == 0)
                  chk("R2 integer step", timer_value, base + prod[95:32]);
               else
                  chk("R3 fractional step", timer_value, base + prod[95:32]);
               chk("R4 step size",
                   {63'd0, ((timer_value - prev) == {32'd0, ints[i]}) ||
                           ((timer_value - prev) == {32'd0, ints[i]} + 64'd1)}, 64'd1);
               prev = timer_value;
            end
         end
      end

      // 10 ns ticks at 50 MHz: step 2.0
      set_inc(32'd2, 32'd0);
      set_timer(64'd0);
      repeat (5000) @(negedge clk);
      chk("R2 100us is 10000 ticks", timer_value, 64'd10000);

      // silent wrap
      set_inc(32'd1, 32'h8000_0000);
      set_timer(64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk); chk("R4 wrap to zero", timer_value, 64'd0);
      @(negedge clk); chk("R4 after wrap", timer_value, 64'd2);

      // write priority and fraction clear
      set_inc(32'd3, 32'd0);
      set_timer(64'd1000);
      reg_write(3'd0, 32'd50);
      chk("R6 write over increment", timer_value, 64'd50);
      set_inc(32'd0, 32'h8000_0000);
      set_timer(64'd10);
      @(negedge clk); chk("R6 half step hidden", timer_value, 64'd10);
      reg_write(3'd0, 32'd20);
      chk("R6 load", timer_value, 64'd20);
      @(negedge clk); chk("R6 fraction cleared", timer_value, 64'd20);
      @(negedge clk); chk("R6 fraction cleared next", timer_value, 64'd21);

      // high-half capture
      set_inc(32'd1, 32'd0);
      set_timer(64'h0000_0007_FFFF_FFF0);
      reg_read(3'd0, rd); chk("R9 low half", {32'd0, rd}, 64'hFFFF_FFF0);
      repeat (20) @(negedge clk);
      reg_read(3'd1, rd); chk("R9 captured high", {32'd0, rd}, 64'd7);
      chk("R9 live high moved", {32'd0, timer_value[63:32]}, 64'd8);

      // interrupt
      set_inc(32'd0, 32'd0);
      set_timer(64'd100);
      reg_write(3'd2, 32'd100);
      chk("R7 cmp hi still ones", {63'd0, timer_irq}, 64'd0);
      reg_write(3'd3, 32'd0);
      chk("R7 irq on equal", {63'd0, timer_irq}, 64'd1);
      reg_write(3'd2, 32'd101);
      chk("R7 irq drops after raise", {63'd0, timer_irq}, 64'd0);
      set_inc(32'd1, 32'd0);
      set_timer(64'd90);
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         chk("R7 irq tracks timer", {63'd0, timer_irq}, {63'd0, (90 + k) >= 101});
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule